// File: doc/BRIEF.md
# Time-Aware Gate Schedule Sequencer

This block drives the per-traffic-class transmission gates of a switch egress port from a gate control list. The list lives in one shared table of entries. Each entry gives a hold time in delta units and the set of gates to close while the entry is current. Up to eight subschedules run over that table. Each subschedule owns a contiguous slice of it, starts at its own entry point, and loops over the slice without end. Each subschedule drives its own group of gate outputs.

Software loads the table, the last index of each slice, the entry points with their phase offsets, the number of active subschedules and a 64-bit base time, all while the engine is stopped. A start command arms the engine. Once the time input reaches the base time, the engine runs. Each clock is one tick, 25 ticks make one delta unit, and every subschedule waits its own phase offset before it enters its first entry. A stop command returns all gates to open on the next tick.

Top module: `tgs_gate_sequencer`

## Requirements
- R1: After reset, gate_closed is all zeros (every gate open), and enabled, running and cfg_err are 0.
- R2: An entry write (wr_sel=0) takes the hold time from wr_data[15:0] in delta units and the open-gate mask from wr_data[23:16], and stores the inverted mask, so a 1 in the output means closed. A write with a hold time of 0 is rejected: cfg_err pulses for one cycle and the table is unchanged.
- R3: A start command raises enabled in the next cycle. running stays 0 and all gates stay open until a clock edge at which ptp_now >= base time. running is 1 from the cycle after that edge. If the base time is already past, running rises two cycles after the start command cycle.
- R4: Running cycle n (n=0 being the first cycle with running=1) belongs to delta period k=n/25. A started subschedule holds each entry for exactly its hold time in delta periods and then moves to the next index. While an entry is current, subschedule s drives that entry's closed mask on gate_closed[8s+7:8s].
- R5: After holding the entry at its end index (wr_sel=1, addr=s, data[3:0]), subschedule s wraps back to its entry-point address.
- R6: The entry point of subschedule s (wr_sel=2, addr=s) gives its start address in data[3:0] and its phase in delta units in data[31:16]. Its gates stay open for the first phase*25 running cycles, and then it enters the entry at its start address.
- R7: Only subschedules 0 to A run, where A is written with wr_sel=3, addr=0, data[2:0]. Higher subschedules keep their gates open. The base time is written with wr_sel=3: addr=1 loads the low 32 bits and addr=2 loads the high 32 bits.
- R8: A stop command (cmd_stop=1 with cmd_start=0) clears running and enabled in the next cycle and opens all gates.
- R9: While enabled=1, the engine ignores the following and pulses cfg_err for one cycle: a start command, any configuration write, or a start and a stop asserted together. A configuration write while stopped is accepted with cfg_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Target: 0 entry, 1 end index, 2 entry point, 3 misc |
| wr_addr | input | 4 | Entry index, subschedule number or misc register |
| wr_data | input | 32 | Write data |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| ptp_now | input | 64 | Current time, same scale as the base time |
| gate_closed | output | 64 | Per-subschedule closed-gate masks, 8 bits each |
| enabled | output | 1 | Engine armed or running |
| running | output | 1 | Schedule executing |
| cfg_err | output | 1 | One-cycle pulse on a rejected command or write |

## Verification
A wrong index, hold counter or phase counter inside a subschedule shows as a wrong mask on its output group. The error appears at the first delta boundary where the bad state is used, which is at most one hold time later, and it then repeats on every lap of that slice. A prescaler that is off by even one tick moves every later entry change by one cycle. The bench therefore compares every output group in every running cycle with a model computed from the written configuration. That comparison covers several laps of each slice, a mid-slice entry point, phase offsets, and injected commands and writes that must be ignored.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_END   = 2'd1,
    SEL_EP    = 2'd2,
    SEL_MISC  = 2'd3
  } wr_sel_e;

  localparam int MISC_ACT   = 0;
  localparam int MISC_BASEL = 1;
  localparam int MISC_BASEH = 2;
  localparam int EP_DELTA_LSB = 16;
endpackage

// File: rtl/tgs_cfg_store.sv
module tgs_cfg_store #(
  parameter int DEPTH = 16,
  parameter int NSUB  = 8,
  parameter int NTC   = 8,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SUB_W = $clog2(NSUB),
  localparam int AW    = (IDX_W > SUB_W) ? IDX_W : SUB_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_sel,
  input  logic [AW-1:0]                wr_addr,
  input  logic [31:0]                  wr_data,
  output logic                         wr_reject,
  output logic [DEPTH-1:0][DW-1:0]     tbl_dur,
  output logic [DEPTH-1:0][NTC-1:0]    tbl_mask,
  output logic [NSUB-1:0][IDX_W-1:0]   end_idx,
  output logic [NSUB-1:0][IDX_W-1:0]   ep_addr,
  output logic [NSUB-1:0][DW-1:0]      ep_delta,
  output logic [SUB_W-1:0]             act_cnt,
  output logic [63:0]                  base_time
);
  import tgs_pkg::*;

  wr_sel_e sel;
  logic    zero_dur;
  logic    wr_ok;

  assign sel       = wr_sel_e'(wr_sel);
  assign zero_dur  = (wr_data[DW-1:0] == '0);
  assign wr_reject = wr_en && (en || (sel == SEL_ENTRY && zero_dur));
  assign wr_ok     = wr_en && !wr_reject;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl_dur[i]  <= DW'(1);
        tbl_mask[i] <= '0;
      end
      end_idx   <= '0;
      ep_addr   <= '0;
      ep_delta  <= '0;
      act_cnt   <= '0;
      base_time <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_ENTRY: begin
          tbl_dur[wr_addr[IDX_W-1:0]]  <= wr_data[DW-1:0];
          tbl_mask[wr_addr[IDX_W-1:0]] <= ~wr_data[DW +: NTC];
        end
        SEL_END: end_idx[wr_addr[SUB_W-1:0]] <= wr_data[IDX_W-1:0];
        SEL_EP: begin
          ep_addr[wr_addr[SUB_W-1:0]]  <= wr_data[IDX_W-1:0];
          ep_delta[wr_addr[SUB_W-1:0]] <= wr_data[EP_DELTA_LSB +: DW];
        end
        default: begin
          if (int'(wr_addr) == MISC_ACT)   act_cnt          <= wr_data[SUB_W-1:0];
          if (int'(wr_addr) == MISC_BASEL) base_time[31:0]  <= wr_data;
          if (int'(wr_addr) == MISC_BASEH) base_time[63:32] <= wr_data;
        end
      endcase
    end
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    en |=> ($stable(tbl_dur) && $stable(tbl_mask) && $stable(act_cnt)));
endmodule

// File: rtl/tgs_ctrl.sv
module tgs_ctrl #(
  parameter int TPD = 25
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_start,
  input  logic        cmd_stop,
  input  logic [63:0] ptp_now,
  input  logic [63:0] base_time,
  input  logic        wr_reject,
  output logic        en_q,
  output logic        run_q,
  output logic        run_nxt,
  output logic        start_evt,
  output logic        strobe,
  output logic        err_q
);
  localparam int PW = (TPD > 1) ? $clog2(TPD) : 1;

  logic [PW-1:0] pre_q;
  logic start_ok, start_bad, stop_ok, base_hit;

  assign start_ok  = cmd_start && !cmd_stop && !en_q;
  assign start_bad = cmd_start && (cmd_stop || en_q);
  assign stop_ok   = cmd_stop && !cmd_start;
  assign base_hit  = (ptp_now >= base_time);
  assign start_evt = en_q && !run_q && base_hit && !stop_ok;
  assign run_nxt   = !stop_ok && (run_q || start_evt);
  assign strobe    = run_q && run_nxt && (pre_q == PW'(TPD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      pre_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (stop_ok)       en_q <= 1'b0;
      else if (start_ok) en_q <= 1'b1;
      run_q <= run_nxt;
      if (!run_nxt || !run_q)            pre_q <= '0;
      else if (pre_q == PW'(TPD - 1))    pre_q <= '0;
      else                               pre_q <= pre_q + PW'(1);
      err_q <= start_bad || wr_reject;
    end
  end

  assert_run_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    run_q |-> en_q);
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_stop && !cmd_start) |=> (!run_q && !en_q));
  assert_bad_start_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && en_q) |=> (err_q && en_q));
endmodule

// File: rtl/tgs_sub_engine.sv
module tgs_sub_engine #(
  parameter int DEPTH = 16,
  parameter int NTC   = 8,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      running,
  input  logic                      run_nxt,
  input  logic                      start_evt,
  input  logic                      strobe,
  input  logic                      is_active,
  input  logic [IDX_W-1:0]          ep_addr,
  input  logic [DW-1:0]             ep_delta,
  input  logic [IDX_W-1:0]          end_idx,
  input  logic [DEPTH-1:0][DW-1:0]  tbl_dur,
  input  logic [DEPTH-1:0][NTC-1:0] tbl_mask,
  output logic [NTC-1:0]            gate_q
);
  logic             started_q, started_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [DW-1:0]    rem_q, rem_n, wait_q, wait_n;

  always_comb begin
    started_n = started_q;
    idx_n     = idx_q;
    rem_n     = rem_q;
    wait_n    = wait_q;
    if (!run_nxt) begin
      started_n = 1'b0;
    end else if (start_evt) begin
      if (ep_delta == '0) begin
        started_n = 1'b1;
        idx_n     = ep_addr;
        rem_n     = tbl_dur[ep_addr];
      end else begin
        started_n = 1'b0;
        wait_n    = ep_delta;
      end
    end else if (strobe && is_active) begin
      if (!started_q) begin
        if (wait_q == DW'(1)) begin
          started_n = 1'b1;
          idx_n     = ep_addr;
          rem_n     = tbl_dur[ep_addr];
        end else begin
          wait_n = wait_q - DW'(1);
        end
      end else if (rem_q == DW'(1)) begin
        idx_n = (idx_q == end_idx) ? ep_addr : idx_q + IDX_W'(1);
        rem_n = tbl_dur[idx_n];
      end else begin
        rem_n = rem_q - DW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      idx_q     <= '0;
      rem_q     <= DW'(1);
      wait_q    <= '0;
      gate_q    <= '0;
    end else begin
      started_q <= started_n;
      idx_q     <= idx_n;
      rem_q     <= rem_n;
      wait_q    <= wait_n;
      gate_q    <= (started_n && is_active) ? tbl_mask[idx_n] : '0;
    end
  end

  assert_idle_open_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> (gate_q == '0));
  assert_hold_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    started_q |-> (rem_q != '0));
  assert_inactive_open_R7: assert property (@(posedge clk) disable iff (rst)
    !is_active |-> (gate_q == '0));
endmodule

// File: rtl/tgs_gate_sequencer.sv
module tgs_gate_sequencer #(
  parameter int DEPTH = 16,
  parameter int NSUB  = 8,
  parameter int NTC   = 8,
  parameter int DW    = 16,
  parameter int TPD   = 25,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SUB_W = $clog2(NSUB),
  localparam int AW    = (IDX_W > SUB_W) ? IDX_W : SUB_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [AW-1:0]       wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                cmd_start,
  input  logic                cmd_stop,
  input  logic [63:0]         ptp_now,
  output logic [NSUB*NTC-1:0] gate_closed,
  output logic                enabled,
  output logic                running,
  output logic                cfg_err
);
  logic [DEPTH-1:0][DW-1:0]   tbl_dur;
  logic [DEPTH-1:0][NTC-1:0]  tbl_mask;
  logic [NSUB-1:0][IDX_W-1:0] end_idx, ep_addr;
  logic [NSUB-1:0][DW-1:0]    ep_delta;
  logic [SUB_W-1:0]           act_cnt;
  logic [63:0]                base_time;
  logic wr_reject, en_q, run_q, run_nxt, start_evt, strobe, err_q;

  tgs_cfg_store #(.DEPTH(DEPTH), .NSUB(NSUB), .NTC(NTC), .DW(DW)) cfg_i (
    .clk(clk), .rst(rst), .en(en_q), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_reject(wr_reject),
    .tbl_dur(tbl_dur), .tbl_mask(tbl_mask), .end_idx(end_idx),
    .ep_addr(ep_addr), .ep_delta(ep_delta), .act_cnt(act_cnt),
    .base_time(base_time)
  );

  tgs_ctrl #(.TPD(TPD)) ctrl_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .ptp_now(ptp_now), .base_time(base_time), .wr_reject(wr_reject),
    .en_q(en_q), .run_q(run_q), .run_nxt(run_nxt), .start_evt(start_evt),
    .strobe(strobe), .err_q(err_q)
  );

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    logic          act_s;
    logic [NTC-1:0] gate_s;
    assign act_s = (s <= int'(act_cnt));
    tgs_sub_engine #(.DEPTH(DEPTH), .NTC(NTC), .DW(DW)) eng_i (
      .clk(clk), .rst(rst), .running(run_q), .run_nxt(run_nxt),
      .start_evt(start_evt), .strobe(strobe), .is_active(act_s),
      .ep_addr(ep_addr[s]), .ep_delta(ep_delta[s]), .end_idx(end_idx[s]),
      .tbl_dur(tbl_dur), .tbl_mask(tbl_mask), .gate_q(gate_s)
    );
    assign gate_closed[s*NTC +: NTC] = gate_s;
  end

  assign enabled = en_q;
  assign running = run_q;
  assign cfg_err = err_q;
endmodule

// File: tb/tgs_gate_sequencer_tb_top.sv
module tgs_gate_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [3:0]  wr_addr = 4'd0;
  logic [31:0] wr_data = 32'd0;
  logic        cmd_start = 1'b0;
  logic        cmd_stop = 1'b0;
  logic [63:0] ptp_now = 64'd0;
  logic [63:0] gate_closed;
  logic        enabled, running, cfg_err;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [15:0] dur[16];
  logic [7:0]  openm[16];
  int ep[8], dl[8], endi[8];
  int act;
  logic [63:0] base;

  tgs_gate_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .ptp_now(ptp_now), .gate_closed(gate_closed), .enabled(enabled),
    .running(running), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) ptp_now <= ptp_now + 64'd1;

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input int sel, input int addr, input logic [31:0] d,
                    input bit exp_err, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = 4'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tag, {63'd0, cfg_err}, {63'd0, exp_err});
  endtask

  task automatic load_all();
    for (int i = 0; i < 16; i++) wr(0, i, {8'd0, openm[i], dur[i]}, 1'b0, "R2");
    for (int s = 0; s < 8; s++) begin
      wr(1, s, 32'(endi[s]), 1'b0, "R5");
      wr(2, s, {16'(dl[s]), 16'(ep[s])}, 1'b0, "R6");
    end
    wr(3, 0, 32'(act), 1'b0, "R7");
  endtask

  // expected closed mask of subschedule s in running cycle n; tag chosen by case
  function automatic logic [7:0] exp_sub(input int s, input int n, output string tag);
    int k, len, i;
    k = n / 25;
    if (s > act) begin tag = "R7"; return 8'h00; end
    if (k < dl[s]) begin tag = "R6"; return 8'h00; end
    k = k - dl[s];
    len = 0;
    for (int j = ep[s]; j <= endi[s]; j++) len += int'(dur[j]);
    tag = (k >= len) ? "R5" : "R4";
    k = k % len;
    i = ep[s];
    while (k >= int'(dur[i])) begin k -= int'(dur[i]); i++; end
    return ~openm[i];
  endfunction

  task automatic sweep(input int ncyc, input bit inject);
    bit run_exp = 0;
    bit en_prev = 0;
    int n = 0;
    string tag;
    logic [7:0] e;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      cmd_start = 1'b0;
      wr_en = 1'b0;
      if (!run_exp && en_prev && ((ptp_now - 64'd1) >= base)) run_exp = 1;
      en_prev = 1;
      chk("R3 running", {63'd0, running}, {63'd0, run_exp});
      chk("R3 enabled", {63'd0, enabled}, 64'd1);
      if (run_exp) begin
        for (int s = 0; s < 8; s++) begin
          e = exp_sub(s, n, tag);
          chk(tag, {56'd0, gate_closed[s*8 +: 8]}, {56'd0, e});
        end
        n++;
      end else begin
        chk("R3 gates open before base", gate_closed, 64'd0);
      end
      if (inject && (c == 201 || c == 301)) chk("R9 ignored cmd/write", {63'd0, cfg_err}, 64'd1);
      if (inject && c == 200) cmd_start = 1'b1;
      if (inject && c == 300) begin
        wr_en = 1'b1; wr_sel = 2'd0; wr_addr = 4'd0; wr_data = 32'h0000_0007;
      end
    end
  endtask

  task automatic do_stop();
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    chk("R8 running", {63'd0, running}, 64'd0);
    chk("R8 enabled", {63'd0, enabled}, 64'd0);
    chk("R8 gates", gate_closed, 64'd0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 gates", gate_closed, 64'd0);
    chk("R1 status", {61'd0, enabled, running, cfg_err}, 64'd0);

    // first configuration: three subschedules
    dur[0]=2; openm[0]=8'h0F; dur[1]=1; openm[1]=8'hF0; dur[2]=3; openm[2]=8'h55;
    dur[3]=1; openm[3]=8'h33; dur[4]=2; openm[4]=8'hCC; dur[5]=1; openm[5]=8'h81;
    dur[6]=2; openm[6]=8'h3C;
    for (int i = 7; i < 16; i++) begin dur[i] = 1; openm[i] = 8'hFF; end
    ep[0]=0; dl[0]=0; endi[0]=2;
    ep[1]=3; dl[1]=2; endi[1]=5;
    ep[2]=6; dl[2]=1; endi[2]=6;
    for (int s = 3; s < 8; s++) begin ep[s]=6; dl[s]=0; endi[s]=6; end
    act = 2;
    load_all();
    // zero-duration write must be rejected and leave entry 6 intact
    wr(0, 6, 32'h00FF_0000, 1'b1, "R2 zero hold");
    base = ptp_now + 64'd80;
    wr(3, 1, base[31:0], 1'b0, "R7 base");
    wr(3, 2, base[63:32], 1'b0, "R7 base");
    @(negedge clk);
    cmd_start = 1'b1;
    sweep(700, 1);
    do_stop();

    // second configuration: mid-slice entry point, base already past
    act = 1;
    ep[0]=1; dl[0]=1;
    ep[1]=4; dl[1]=0;
    wr(2, 0, {16'(dl[0]), 16'(ep[0])}, 1'b0, "R9 write while stopped");
    wr(2, 1, {16'(dl[1]), 16'(ep[1])}, 1'b0, "R6");
    wr(3, 0, 32'(act), 1'b0, "R7");
    base = ptp_now - 64'd5;
    wr(3, 1, base[31:0], 1'b0, "R7 base");
    wr(3, 2, base[63:32], 1'b0, "R7 base");
    @(negedge clk);
    cmd_start = 1'b1;
    sweep(500, 0);
    do_stop();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule